// File: doc/BRIEF.md
# Byte-Pair IDE Register Bridge

This block lets a host with an 8-bit data bus reach the 16-bit task-file registers of an IDE drive. Software touches each drive register with a 16-bit memory load or store. The CPU breaks that access into two byte cycles, even byte first and then odd byte. The bridge joins the two halves with one 8-bit holding register. Reads and writes treat the two halves in opposite ways.

On a load, the even-byte cycle runs the real drive read. The host gets the low drive byte at once, and the high drive byte goes into the holding register. The odd-byte cycle then returns the held byte and does not touch the drive. On a store, the even-byte cycle only parks the host byte in the holding register. The odd-byte cycle runs the real drive write: the held byte goes on the low drive lane and the current host byte goes on the high lane.

The drive registers sit one per 16-bit word in a 16-byte window. Host address bits 3..1 therefore become the drive register address. Address decoding above the window is done outside the block and arrives as a region select.

Top module: `ide_byte_bridge`

## Requirements
- R1: During a drive cycle, `ide_da` equals host `addr[3:1]`.
- R2: A read with `addr[0]`=0 while selected asserts `ide_cs0_n` and `ide_dior_n` low for the whole strobe, and `hdata_out` carries `ide_din[7:0]`.
- R3: A read with `addr[0]`=0 while selected leaves `ide_din[15:8]` in the holding register, as sampled at the last clock edge of the strobe.
- R4: A read with `addr[0]`=1 while selected returns the holding register on `hdata_out`. It starts no drive cycle and leaves the holding register unchanged.
- R5: A write with `addr[0]`=0 while selected stores `hdata_in` in the holding register and starts no drive cycle.
- R6: A write with `addr[0]`=1 while selected asserts `ide_cs0_n` and `ide_diow_n` low and drives `ide_dout` = {`hdata_in`, holding register}. The holding register is not changed.
- R7: `ide_dior_n` and `ide_diow_n` go low only while `ide_cs0_n` is low.
- R8: `ide_doe` is high only during a selected write with `addr[0]`=1.
- R9: Reset clears the holding register to 0x00.
- R10: With `sel` low, strobes start no drive cycle and leave the holding register unchanged.
- R11: If `hrd` and `hwr` are both high, the block starts no drive cycle and leaves the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the holding register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Host address falls in the drive register window |
| addr | input | 4 | Host address bits 3..0 |
| hrd | input | 1 | Host read strobe, active high |
| hwr | input | 1 | Host write strobe, active high |
| hdata_in | input | 8 | Host write data |
| hdata_out | output | 8 | Host read data |
| ide_da | output | 3 | Drive register address |
| ide_cs0_n | output | 1 | Drive task-file select, active low |
| ide_dior_n | output | 1 | Drive read strobe, active low |
| ide_diow_n | output | 1 | Drive write strobe, active low |
| ide_din | input | 16 | Data read from the drive bus |
| ide_dout | output | 16 | Data driven onto the drive bus |
| ide_doe | output | 1 | Output enable for the drive bus drivers |

## Verification
The bench uses the default `HOLD_RESET` of 0x00, so the holding register is known right after reset. The block has so few inputs that the bench sweeps every combination of select, strobe pair and all 16 addresses. That sweep covers every register slot, both byte halves, and the conflicting and unselected strobe cases. After each access, an odd-address read brings the holding register out, so the bench can see what each access did to it. A 0xA55A round trip in both directions closes the run.

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge #(
  parameter logic [7:0] HOLD_RESET = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic [3:0]  addr,
  input  logic        hrd,
  input  logic        hwr,
  input  logic [7:0]  hdata_in,
  output logic [7:0]  hdata_out,
  output logic [2:0]  ide_da,
  output logic        ide_cs0_n,
  output logic        ide_dior_n,
  output logic        ide_diow_n,
  input  logic [15:0] ide_din,
  output logic [15:0] ide_dout,
  output logic        ide_doe
);

  logic [7:0] hold;
  logic       rd_ok, wr_ok, odd;
  logic       rd_even, wr_odd, wr_even;

  assign odd     = addr[0];
  assign rd_ok   = sel && hrd && !hwr;
  assign wr_ok   = sel && hwr && !hrd;
  assign rd_even = rd_ok && !odd;
  assign wr_even = wr_ok && !odd;
  assign wr_odd  = wr_ok && odd;

  assign ide_da     = addr[3:1];
  assign ide_cs0_n  = !(rd_even || wr_odd);
  assign ide_dior_n = !rd_even;
  assign ide_diow_n = !wr_odd;
  assign ide_doe    = wr_odd;
  assign ide_dout   = {hdata_in, hold};
  assign hdata_out  = odd ? hold : ide_din[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold <= HOLD_RESET;
    else if (rd_even) hold <= ide_din[15:8];
    else if (wr_even) hold <= hdata_in;
  end

endmodule

module ide_byte_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic [3:0]  addr,
  input logic        hrd,
  input logic        hwr,
  input logic [7:0]  hdata_in,
  input logic [7:0]  hdata_out,
  input logic [2:0]  ide_da,
  input logic        ide_cs0_n,
  input logic        ide_dior_n,
  input logic        ide_diow_n,
  input logic [15:0] ide_din,
  input logic        ide_doe,
  input logic [7:0]  hold
);

  assert_da_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_cs0_n |-> ide_da == addr[3:1]);

  assert_even_read_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hrd && !hwr && !addr[0]) |-> (!ide_dior_n && hdata_out == ide_din[7:0]));

  assert_even_read_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hrd && !hwr && !addr[0]) |=> hold == $past(ide_din[15:8]));

  assert_odd_read_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hrd && !hwr && addr[0]) |-> (hdata_out == hold && ide_cs0_n));

  assert_odd_keeps_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && addr[0]) |=> $stable(hold));

  assert_even_write_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hwr && !hrd && !addr[0]) |=> hold == $past(hdata_in));

  assert_odd_write_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hwr && !hrd && addr[0]) |-> (!ide_diow_n && !ide_cs0_n));

  assert_dior_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_dior_n |-> !ide_cs0_n);

  assert_diow_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_diow_n |-> !ide_cs0_n);

  assert_doe_odd_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ide_doe |-> (sel && hwr && !hrd && addr[0]));

  assert_unselected_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(hold) && $past(ide_cs0_n)));

  assert_both_strobes_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hrd && hwr) |=> ($stable(hold) && $past(ide_cs0_n)));

endmodule

bind ide_byte_bridge ide_byte_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .hrd(hrd), .hwr(hwr),
  .hdata_in(hdata_in), .hdata_out(hdata_out), .ide_da(ide_da),
  .ide_cs0_n(ide_cs0_n), .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
  .ide_din(ide_din), .ide_doe(ide_doe), .hold(hold)
);

// File: tb/ide_byte_bridge_tb.sv
`timescale 1ns/1ps
module ide_byte_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic        hrd = 1'b0;
  logic        hwr = 1'b0;
  logic [7:0]  hdata_in = 8'h00;
  logic [7:0]  hdata_out;
  logic [2:0]  ide_da;
  logic        ide_cs0_n, ide_dior_n, ide_diow_n, ide_doe;
  logic [15:0] ide_din = 16'h0000;
  logic [15:0] ide_dout;

  int checks = 0;
  int failures = 0;
  logic [7:0] model = 8'h00;

  always #5 clk = ~clk;

  ide_byte_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .hrd(hrd), .hwr(hwr),
    .hdata_in(hdata_in), .hdata_out(hdata_out), .ide_da(ide_da),
    .ide_cs0_n(ide_cs0_n), .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
    .ide_din(ide_din), .ide_dout(ide_dout), .ide_doe(ide_doe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic s, input logic r, input logic w, input logic [3:0] a,
                    input logic [7:0] d, input logic [15:0] din, input string tag);
    logic cyc, rde, wro;
    @(negedge clk);
    sel = s; hrd = r; hwr = w; addr = a; hdata_in = d; ide_din = din;
    rde = s && r && !w && !a[0];
    wro = s && w && !r && a[0];
    cyc = rde || wro;
    #2;
    chk({tag, " cs0"}, ide_cs0_n, !cyc);
    chk("R7 dior", ide_dior_n, !rde);
    chk("R7 diow", ide_diow_n, !wro);
    chk("R8 doe", ide_doe, wro);
    if (cyc) chk("R1 da", ide_da, a[3:1]);
    if (rde) chk("R2 low byte", hdata_out, din[7:0]);
    if (s && r && !w && a[0]) chk("R4 held byte", hdata_out, model);
    if (wro) chk("R6 dout", ide_dout, {d, model});
    @(posedge clk);
    if (rde) model = din[15:8];
    else if (s && w && !r && !a[0]) model = d;
    @(negedge clk);
    sel = 1'b0; hrd = 1'b0; hwr = 1'b0;
  endtask

  task automatic readback(input string tag);
    @(negedge clk);
    sel = 1'b1; hrd = 1'b1; hwr = 1'b0; addr = 4'h1;
    #2;
    chk(tag, hdata_out, model);
    chk("R4 no cycle", ide_cs0_n, 1'b1);
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; hrd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    readback("R9 reset value");
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 4; k++) begin
        for (int a = 0; a < 16; a++) begin
          logic [7:0] d;
          string tag;
          d = 8'((a * 37 + k * 11 + s * 5) ^ 8'hC3);
          if (s == 0) tag = "R10";
          else if (k == 3) tag = "R11";
          else if (k == 1) tag = (a % 2 == 1) ? "R4" : "R3";
          else if (k == 2) tag = (a % 2 == 1) ? "R6" : "R5";
          else tag = "R10";
          op(s[0], k[0], k[1], a[3:0], d, {d ^ 8'h5A, ~d}, tag);
          readback({tag, " hold after access"});
        end
      end
    end
    op(1'b1, 1'b0, 1'b1, 4'h4, 8'h5A, 16'h0000, "R5");
    op(1'b1, 1'b0, 1'b1, 4'h5, 8'hA5, 16'h0000, "R6");
    op(1'b1, 1'b1, 1'b0, 4'h4, 8'h00, 16'hA55A, "R2");
    readback("R3 round trip high");
    @(negedge clk);
    sel = 1'b1; hwr = 1'b1; addr = 4'hF; hdata_in = 8'hA5;
    #2;
    chk("R6 round trip dout", ide_dout, 16'hA5A5);
    @(negedge clk);
    sel = 1'b0; hwr = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule